// File: doc/BRIEF.md
# Doorbell Mailbox Register Bank

This block holds one 32-bit mailbox word for each of `NUM_FN` virtual functions and lets a privileged primary agent and the functions swap short messages through them. The primary agent reaches every word through one read/write port. Each function has its own read/write port, and hardware limits that port to the word at the function's own index. Writes go in by half-word. Bit 0 enables the low half (bits 15:0) and bit 1 enables the high half (bits 31:16).

The low half carries traffic from the primary to the function. Bit 0 of the low half is a doorbell that raises a level interrupt toward the owning function. The high half carries traffic from the function to the primary. Bit 16 is a doorbell that raises a level interrupt toward the primary, and the primary receives one vector with one bit per function. Inside each half, bit 1 (low) and bit 17 (high) mark the origin of a valid message. A 4-bit message kind sits at bits 5:2 (low) and bits 21:18 (high). The block stores these fields and does not interpret them. A receiver acknowledges a message by writing its doorbell bit back to zero.

When both sides write the same half of the same word in one cycle, the sender of that half wins. The primary wins the low half and the function wins the high half.

Top module: `mailbox_bank`

## Requirements
- R1: After a cycle with `rst` high, every word reads 0 and `fn_irq` and `pri_irq_vec` are all 0.
- R2: A primary write to index k, with half-enable bit 0 (bits 15:0) and/or bit 1 (bits 31:16) set, updates only the enabled halves of word k at the next clock edge. `pri_rdata` returns word `pri_addr` combinationally.
- R3: Function port i may write the enabled halves of word i and read word i through `fn_rdata[i]`, with the same timing as the primary port.
- R4: If function port i addresses an index other than i, its write has no effect on any word and its read returns 0.
- R5: `fn_irq[i]` equals bit 0 of word i. It stays high until bit 0 is written to 0.
- R6: `pri_irq_vec[i]` equals bit 16 of word i. It is level-sensitive and drops only when bit 16 is written to 0.
- R7: If the primary and function i both write the low half of word i in one cycle, the primary's low half is stored.
- R8: If the primary and function i both write the high half of word i in one cycle, the function's high half is stored.
- R9: If the primary and function i write different halves of word i in one cycle, both halves are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_addr | input | IDX_W | Primary port word index (read and write) |
| pri_hen | input | 2 | Primary half-write enables: bit 0 low half, bit 1 high half |
| pri_wdata | input | 32 | Primary write data |
| pri_rdata | output | 32 | Word at `pri_addr` |
| fn_addr | input | NUM_FN x IDX_W | Index used by each function port |
| fn_hen | input | NUM_FN x 2 | Half-write enables for each function port |
| fn_wdata | input | NUM_FN x 32 | Write data for each function port |
| fn_rdata | output | NUM_FN x 32 | Read data for each function port (0 when it addresses another index) |
| fn_irq | output | NUM_FN | Doorbell interrupt to each function (bit 0 of its word) |
| pri_irq_vec | output | NUM_FN | Doorbell vector to the primary (bit 16 of each word) |

## Verification
A primary write and a write from the owning function can land on the same word in the same clock cycle. The bench drives both ports in a single cycle in three ways: both on the low half, both on the high half, and each on a different half. It then reads the word back through the primary port and checks the result against the sender-wins rule. It also checks the interrupt line for the half that was contended.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    // Half-word layout: payload, message kind, origin flag, doorbell
    typedef struct packed {
        logic [9:0] payload;
        logic [3:0] kind;
        logic       origin;
        logic       bell;
    } mbx_half_t;

    typedef struct packed {
        mbx_half_t up;   // function -> primary, bits 31:16
        mbx_half_t dn;   // primary -> function, bits 15:0
    } mbx_word_t;

    typedef enum logic [1:0] {
        HEN_NONE = 2'b00,
        HEN_DN   = 2'b01,
        HEN_UP   = 2'b10,
        HEN_BOTH = 2'b11
    } mbx_hen_e;

    function automatic mbx_word_t to_word(input logic [WORD_W-1:0] raw);
        return mbx_word_t'(raw);
    endfunction

endpackage

// File: rtl/mbx_fence.sv
module mbx_fence #(
    parameter int IDX_W = 2,
    parameter int SELF  = 0
) (
    input  logic [IDX_W-1:0] addr,
    input  logic [1:0]       hen,
    input  logic [31:0]      word_q,
    output logic [1:0]       hen_ok,
    output logic [31:0]      rdata
);
    logic own;

    always_comb begin
        own    = (addr == IDX_W'(SELF));
        hen_ok = own ? hen : 2'b00;
        rdata  = own ? word_q : '0;
    end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  pri_hen,
    input  logic [31:0] pri_wdata,
    input  logic [1:0]  fn_hen,
    input  logic [31:0] fn_wdata,
    output logic [31:0] word_q,
    output logic        dn_bell,
    output logic        up_bell
);
    mbx_word_t cur, nxt, pw, fw;

    always_comb begin
        pw  = to_word(pri_wdata);
        fw  = to_word(fn_wdata);
        nxt = cur;
        // Low half: the primary is its sender and wins a contended write
        if (pri_hen[0])
            nxt.dn = pw.dn;
        else if (fn_hen[0])
            nxt.dn = fw.dn;
        // High half: the function is its sender and wins a contended write
        if (fn_hen[1])
            nxt.up = fw.up;
        else if (pri_hen[1])
            nxt.up = pw.up;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= nxt;
    end

    assign word_q  = cur;
    assign dn_bell = cur.dn.bell;
    assign up_bell = cur.up.bell;

endmodule

// File: rtl/mailbox_bank.sv
module mailbox_bank
    import mbx_pkg::*;
#(
    parameter int NUM_FN = 4,
    parameter int IDX_W  = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [IDX_W-1:0]               pri_addr,
    input  logic [1:0]                     pri_hen,
    input  logic [31:0]                    pri_wdata,
    output logic [31:0]                    pri_rdata,
    input  logic [NUM_FN-1:0][IDX_W-1:0]   fn_addr,
    input  logic [NUM_FN-1:0][1:0]         fn_hen,
    input  logic [NUM_FN-1:0][31:0]        fn_wdata,
    output logic [NUM_FN-1:0][31:0]        fn_rdata,
    output logic [NUM_FN-1:0]              fn_irq,
    output logic [NUM_FN-1:0]              pri_irq_vec
);
    logic [NUM_FN-1:0][31:0] words;

    for (genvar i = 0; i < NUM_FN; i++) begin : g_slot
        logic [1:0] pri_hen_i;
        logic [1:0] fn_hen_i;

        assign pri_hen_i = (pri_addr == IDX_W'(i)) ? pri_hen : 2'b00;

        mbx_fence #(.IDX_W(IDX_W), .SELF(i)) u_fence (
            .addr   (fn_addr[i]),
            .hen    (fn_hen[i]),
            .word_q (words[i]),
            .hen_ok (fn_hen_i),
            .rdata  (fn_rdata[i])
        );

        mbx_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .pri_hen   (pri_hen_i),
            .pri_wdata (pri_wdata),
            .fn_hen    (fn_hen_i),
            .fn_wdata  (fn_wdata[i]),
            .word_q    (words[i]),
            .dn_bell   (fn_irq[i]),
            .up_bell   (pri_irq_vec[i])
        );
    end

    always_comb begin
        pri_rdata = '0;
        for (int k = 0; k < NUM_FN; k++)
            if (pri_addr == IDX_W'(k))
                pri_rdata = words[k];
    end

endmodule

// File: rtl/mailbox_bank_chk.sv
module mailbox_bank_chk #(
    parameter int NUM_FN = 4,
    parameter int IDX_W  = 2
) (
    input logic                         clk,
    input logic                         rst,
    input logic [IDX_W-1:0]             pri_addr,
    input logic [1:0]                   pri_hen,
    input logic [31:0]                  pri_wdata,
    input logic [31:0]                  pri_rdata,
    input logic [NUM_FN-1:0][IDX_W-1:0] fn_addr,
    input logic [NUM_FN-1:0][1:0]       fn_hen,
    input logic [NUM_FN-1:0][31:0]      fn_wdata,
    input logic [NUM_FN-1:0][31:0]      fn_rdata,
    input logic [NUM_FN-1:0]            fn_irq,
    input logic [NUM_FN-1:0]            pri_irq_vec
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_q) begin
            reset_clear_chk: assert (fn_irq == '0 && pri_irq_vec == '0 && pri_rdata == '0);
        end
    end

    for (genvar i = 0; i < NUM_FN; i++) begin : g_chk
        // R4
        always_comb begin
            if (!rst && fn_addr[i] != IDX_W'(i)) begin
                fence_read_chk: assert (fn_rdata[i] == '0);
            end
        end

        // R7
        pri_low_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(pri_addr) == IDX_W'(i) && $past(pri_hen[0]))
            |-> fn_irq[i] == $past(pri_wdata[0]));

        // R8
        fn_high_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(fn_addr[i]) == IDX_W'(i) && $past(fn_hen[i][1]))
            |-> pri_irq_vec[i] == $past(fn_wdata[i][16]));

        // R6
        up_bell_source_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pri_irq_vec[i]) |->
            (($past(pri_addr) == IDX_W'(i) && $past(pri_hen[1]) && $past(pri_wdata[16])) ||
             ($past(fn_addr[i]) == IDX_W'(i) && $past(fn_hen[i][1]) && $past(fn_wdata[i][16]))));

        // R5
        dn_bell_source_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(fn_irq[i]) |->
            (($past(pri_addr) == IDX_W'(i) && $past(pri_hen[0]) && $past(pri_wdata[0])) ||
             ($past(fn_addr[i]) == IDX_W'(i) && $past(fn_hen[i][0]) && $past(fn_wdata[i][0]))));
    end

endmodule

bind mailbox_bank mailbox_bank_chk #(.NUM_FN(NUM_FN), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_mailbox_bank.sv
`timescale 1ns/1ps
module test_mailbox_bank;
    localparam int N  = 4;
    localparam int IW = 2;

    logic                    clk = 1'b0;
    logic                    rst;
    logic [IW-1:0]           pri_addr;
    logic [1:0]              pri_hen;
    logic [31:0]             pri_wdata;
    logic [31:0]             pri_rdata;
    logic [N-1:0][IW-1:0]    fn_addr;
    logic [N-1:0][1:0]       fn_hen;
    logic [N-1:0][31:0]      fn_wdata;
    logic [N-1:0][31:0]      fn_rdata;
    logic [N-1:0]            fn_irq;
    logic [N-1:0]            pri_irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    mailbox_bank #(.NUM_FN(N)) i_mailbox_bank (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, want %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        pri_hen = 2'b00;
        pri_wdata = '0;
        for (int i = 0; i < N; i++) begin
            fn_addr[i]  = IW'(i);
            fn_hen[i]   = 2'b00;
            fn_wdata[i] = '0;
        end
    endtask

    function automatic logic [31:0] peek_word(input int k);
        return 32'h0;
    endfunction

    // read a word over the primary port between edges
    task automatic pri_read(input int k, output logic [31:0] v);
        pri_addr = IW'(k);
        #1;
        v = pri_rdata;
    endtask

    task automatic pri_wr(input int k, input logic [1:0] hen, input logic [31:0] d);
        @(negedge clk);
        pri_addr = IW'(k); pri_hen = hen; pri_wdata = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic fn_wr(input int f, input int k, input logic [1:0] hen, input logic [31:0] d);
        @(negedge clk);
        fn_addr[f] = IW'(k); fn_hen[f] = hen; fn_wdata[f] = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 0; k < N; k++) begin
            pri_read(k, v);
            chk("R1 word", v, 32'h0);
        end
        chk("R1 fn_irq", 32'(fn_irq), 32'h0);
        chk("R1 pri_irq_vec", 32'(pri_irq_vec), 32'h0);
    endtask

    task automatic t_primary();
        logic [31:0] v;
        pri_wr(2, 2'b11, 32'h1234_0027);
        pri_read(2, v);
        chk("R2 full write", v, 32'h1234_0027);
        chk("R5 bell up", 32'(fn_irq), 32'h4);
        pri_wr(2, 2'b10, 32'hABCD_FFFF);
        pri_read(2, v);
        chk("R2 high-only keeps low", v, 32'hABCD_0027);
        chk("R6 vec", 32'(pri_irq_vec), 32'h4);
        pri_wr(2, 2'b00, 32'hFFFF_FFFF);
        pri_read(2, v);
        chk("R2 no enable no change", v, 32'hABCD_0027);
    endtask

    task automatic t_function();
        logic [31:0] v;
        fn_wr(1, 1, 2'b10, 32'h0007_5555);
        pri_read(1, v);
        chk("R3 own high write", v, 32'h0007_0000);
        chk("R6 vec from fn", 32'(pri_irq_vec), 32'h6);
        fn_addr[1] = IW'(1); #1;
        chk("R3 own read", fn_rdata[1], 32'h0007_0000);
        fn_wr(1, 3, 2'b11, 32'hFFFF_FFFF);
        pri_read(3, v);
        chk("R4 foreign write ignored", v, 32'h0);
        chk("R4 no bell from foreign write", 32'(fn_irq), 32'h4);
        fn_addr[1] = IW'(2); #1;
        chk("R4 foreign read zero", fn_rdata[1], 32'h0);
        fn_addr[1] = IW'(1);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        fn_wr(2, 2, 2'b01, 32'h0000_0026);
        chk("R5 bell cleared", 32'(fn_irq), 32'h0);
        pri_read(2, v);
        chk("R5 other low bits kept", v, 32'hABCD_0026);
        pri_wr(1, 2'b10, 32'h0006_0000);
        chk("R6 vec cleared", 32'(pri_irq_vec), 32'h4);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk);
        pri_addr = 0; pri_hen = 2'b01; pri_wdata = 32'h0000_0003;
        fn_addr[0] = 0; fn_hen[0] = 2'b01; fn_wdata[0] = 32'h0000_00F0;
        @(negedge clk); idle_inputs();
        pri_read(0, v);
        chk("R7 primary wins low", v, 32'h0000_0003);
        chk("R7 bell", 32'(fn_irq), 32'h1);
        @(negedge clk);
        pri_addr = 0; pri_hen = 2'b10; pri_wdata = 32'h0001_0000;
        fn_addr[0] = 0; fn_hen[0] = 2'b10; fn_wdata[0] = 32'h00F2_0000;
        @(negedge clk); idle_inputs();
        pri_read(0, v);
        chk("R8 function wins high", v, 32'h00F2_0003);
        chk("R8 no bell", 32'(pri_irq_vec), 32'h4);
        @(negedge clk);
        pri_addr = 3; pri_hen = 2'b01; pri_wdata = 32'hEEEE_0041;
        fn_addr[3] = 3; fn_hen[3] = 2'b10; fn_wdata[3] = 32'h0083_9999;
        @(negedge clk); idle_inputs();
        pri_read(3, v);
        chk("R9 both halves", v, 32'h0083_0041);
        chk("R9 both bells", 32'({fn_irq, pri_irq_vec}), 32'h9C);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, want completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        pri_addr = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_primary();
        t_function();
        t_ack();
        t_collide();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule